// File: doc/BRIEF.md
# Graphics Palette Expansion and Video Overlay Mixer

This block turns a stream of graphics pixel codes into true colours and lays them over a video pixel stream. Each code is 2, 4 or 8 bits wide. A code can index the colour lookup table (CLUT) directly, or it can first pass through a small remap table. The remap table lets a short code select any chosen subset of a larger palette. Each palette entry carries luma, two chroma components and a 6-bit transparency weight. The weight sets how much of the graphics colour and how much of the video reaches the output, in one of 64 steps.

A host loads the palette and the remap table through a simple write port. Writes are only taken while no graphics box is being drawn, so a palette reload has to fall into the gap between boxes. The pixel path is a three-stage pipeline with no stalls. Video, box flag and valid travel through it with the graphics data, so the output stays aligned with its source pixel.

Top module: `gfxmix_top`

## Requirements
- R1: While reset is asserted and at the first sample after it, out_valid is 0 and out_y, out_u and out_v are 0.
- R2: A pixel sampled at clock edge n appears on the outputs after edge n+2 (three register stages). out_valid repeats pix_valid with the same delay, gaps included.
- R3: The code is first masked to its width by pix_bpp. pix_bpp=0 keeps bits [1:0], pix_bpp=1 keeps bits [3:0], and pix_bpp=2 or 3 keeps all 8 bits.
- R4: With map_mode=0 (direct), the masked code is the palette index itself.
- R5: With map_mode=1 (16 onto 256), the palette index is remap entry [code[3:0]], all 8 bits of it.
- R6: With map_mode=2 (4 onto 256), the palette index is remap entry [code[1:0]], all 8 bits of it.
- R7: With map_mode=3 (4 onto 16), the palette index is bits [3:0] of remap entry [code[1:0]], so only palette entries 0 to 15 can be reached.
- R8: Inside a box, each output component is floor((T*G + (63-T)*V + 31) / 63), where G is the palette component, V is the video component and T is the entry's weight.
- R9: A weight of 63 outputs the palette colour exactly. A weight of 0 outputs the video exactly.
- R10: When box_active is 0 for a pixel, the video for that pixel passes to the output unchanged, whatever the code.
- R11: A write with hw_sel=0 stores hw_data into palette entry hw_addr. The layout is Y in [29:22], U in [21:14], V in [13:6] and T in [5:0]. A write with hw_sel=1 stores hw_data[7:0] into remap entry hw_addr[3:0]. Any write made while box_active is 1 is ignored.
- R12: A palette write taken at edge n+1 does not change the colour of a box pixel sampled at edge n. It does change box pixels sampled at edge n+1 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 1 | Write target: 0 palette, 1 remap table |
| hw_addr | input | 8 | Write address |
| hw_data | input | 30 | Write data (palette layout Y,U,V,T from the MSB down) |
| box_active | input | 1 | Current pixel lies inside a graphics box; also blocks host writes |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_bpp | input | 2 | Code width select |
| map_mode | input | 2 | Index mapping select |
| pix_code | input | 8 | Graphics pixel code |
| vid_y | input | 8 | Video luma |
| vid_u | input | 8 | Video chroma U |
| vid_v | input | 8 | Video chroma V |
| out_valid | output | 1 | Output pixel present |
| out_y | output | 8 | Mixed luma |
| out_u | output | 8 | Mixed chroma U |
| out_v | output | 8 | Mixed chroma V |

## Verification
A host palette write and a palette read for a box pixel can fall in the same cycle. The bench provokes this by ending a box and, in the very next cycle, rewriting the entry that the last box pixel selected. It then sends box pixels that use the same entry. The last box pixel must still show the old colour and the later pixels the new one. The bench also places writes in the same cycle as box pixels and judges them by later readback, which must show the old palette and remap contents. A behavioural model, stepped at every edge in the same read-then-write order the requirements give, supplies the expected values for every cycle.

// File: rtl/gfxmix_pkg.sv
package gfxmix_pkg;
    localparam int COMP_W  = 8;
    localparam int TRANS_W = 6;
    localparam int CODE_W  = 8;
    localparam int CLUT_AW = 8;
    localparam int BMT_AW  = 4;
    localparam int SUB_AW  = 4;

    typedef struct packed {
        logic [COMP_W-1:0]  y;
        logic [COMP_W-1:0]  u;
        logic [COMP_W-1:0]  v;
        logic [TRANS_W-1:0] t;
    } colour_t;

    typedef struct packed {
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] u;
        logic [COMP_W-1:0] v;
    } yuv_t;

    typedef enum logic [1:0] {
        MAP_DIRECT    = 2'd0,
        MAP_16_TO_256 = 2'd1,
        MAP_4_TO_256  = 2'd2,
        MAP_4_TO_16   = 2'd3
    } map_mode_t;

    typedef struct packed {
        logic               vld;
        logic               box;
        logic [CLUT_AW-1:0] idx;
        yuv_t               vid;
    } st_index_t;

    typedef struct packed {
        logic    vld;
        logic    box;
        colour_t col;
        yuv_t    vid;
    } st_colour_t;

    typedef struct packed {
        logic vld;
        yuv_t pix;
    } st_out_t;

    typedef struct packed {
        st_index_t  a;
        st_colour_t b;
        st_out_t    c;
    } pipe_t;
endpackage

// File: rtl/gfxmix_index.sv
module gfxmix_index
    import gfxmix_pkg::*;
#(
    parameter int CW  = CODE_W,
    parameter int AW  = CLUT_AW,
    parameter int TAW = BMT_AW,
    parameter int SW  = SUB_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           box_active,
    input  logic [TAW-1:0] wr_addr,
    input  logic [AW-1:0]  wr_data,
    input  logic [CW-1:0]  code,
    input  logic [1:0]     bpp,
    input  logic [1:0]     mode,
    output logic [AW-1:0]  idx
);
    localparam int ENTRIES = 1 << TAW;

    logic [AW-1:0] tbl_d [ENTRIES];
    logic [AW-1:0] tbl_q [ENTRIES];
    logic          accept;
    logic [CW-1:0] masked;

    assign accept = wr_en && !box_active;

    always_comb begin
        tbl_d = tbl_q;
        if (accept) tbl_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        tbl_q <= tbl_d;
    end

    always_comb begin
        case (bpp)
            2'd0:    masked = code & CW'(3);
            2'd1:    masked = code & CW'(15);
            default: masked = code;
        endcase
    end

    always_comb begin
        case (mode)
            MAP_16_TO_256: idx = tbl_q[masked[TAW-1:0]];
            MAP_4_TO_256:  idx = tbl_q[TAW'(masked[1:0])];
            MAP_4_TO_16:   idx = AW'(tbl_q[TAW'(masked[1:0])][SW-1:0]);
            default:       idx = AW'(masked);
        endcase
    end

    // R11: a write during a box leaves the remap entry untouched
    p_remap_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && box_active) |=> tbl_q[$past(wr_addr)] == $past(tbl_q[wr_addr]));
endmodule

// File: rtl/gfxmix_clut.sv
module gfxmix_clut
    import gfxmix_pkg::*;
#(
    parameter int AW = CLUT_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          box_active,
    input  logic [AW-1:0] wr_addr,
    input  colour_t       wr_data,
    input  logic [AW-1:0] rd_idx,
    output colour_t       rd_col
);
    localparam int ENTRIES = 1 << AW;

    colour_t mem_d [ENTRIES];
    colour_t mem_q [ENTRIES];
    logic    accept;

    assign accept = wr_en && !box_active;

    always_comb begin
        mem_d = mem_q;
        if (accept) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_col = mem_q[rd_idx];

    // R11: palette entries cannot change while a box is active
    p_palette_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && box_active) |=> mem_q[$past(wr_addr)] == $past(mem_q[wr_addr]));
endmodule

// File: rtl/gfxmix_mix.sv
module gfxmix_mix
    import gfxmix_pkg::*;
#(
    parameter int W  = COMP_W,
    parameter int TW = TRANS_W
) (
    input  logic [W-1:0]  gfx,
    input  logic [W-1:0]  vid,
    input  logic [TW-1:0] alpha,
    output logic [W-1:0]  mixed
);
    localparam int TMAX = (1 << TW) - 1;
    localparam int NW   = W + TW + 1;

    logic [NW-1:0] g_ext, v_ext, a_ext, b_ext, num;

    always_comb begin
        g_ext = NW'(gfx);
        v_ext = NW'(vid);
        a_ext = NW'(alpha);
        b_ext = NW'(TMAX) - a_ext;
        num   = g_ext * a_ext + v_ext * b_ext + NW'(TMAX / 2);
        mixed = W'(num / NW'(TMAX));
    end
endmodule

// File: rtl/gfxmix_top.sv
module gfxmix_top
    import gfxmix_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_en,
    input  logic                   hw_sel,
    input  logic [CLUT_AW-1:0]     hw_addr,
    input  logic [$bits(colour_t)-1:0] hw_data,
    input  logic                   box_active,
    input  logic                   pix_valid,
    input  logic [1:0]             pix_bpp,
    input  logic [1:0]             map_mode,
    input  logic [CODE_W-1:0]      pix_code,
    input  logic [COMP_W-1:0]      vid_y,
    input  logic [COMP_W-1:0]      vid_u,
    input  logic [COMP_W-1:0]      vid_v,
    output logic                   out_valid,
    output logic [COMP_W-1:0]      out_y,
    output logic [COMP_W-1:0]      out_u,
    output logic [COMP_W-1:0]      out_v
);
    localparam int NCOMP = 3;

    pipe_t               pipe_d, pipe_q;
    logic [CLUT_AW-1:0]  lut_idx;
    colour_t             lut_col;
    logic [COMP_W-1:0]   c_gfx [NCOMP];
    logic [COMP_W-1:0]   c_vid [NCOMP];
    logic [COMP_W-1:0]   c_mix [NCOMP];

    gfxmix_index #(
        .CW(CODE_W), .AW(CLUT_AW), .TAW(BMT_AW), .SW(SUB_AW)
    ) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (hw_en && hw_sel),
        .box_active (box_active),
        .wr_addr    (hw_addr[BMT_AW-1:0]),
        .wr_data    (hw_data[CLUT_AW-1:0]),
        .code       (pix_code),
        .bpp        (pix_bpp),
        .mode       (map_mode),
        .idx        (lut_idx)
    );

    gfxmix_clut #(.AW(CLUT_AW)) u_clut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (hw_en && !hw_sel),
        .box_active (box_active),
        .wr_addr    (hw_addr),
        .wr_data    (colour_t'(hw_data)),
        .rd_idx     (pipe_q.a.idx),
        .rd_col     (lut_col)
    );

    assign c_gfx[0] = pipe_q.b.col.y;
    assign c_gfx[1] = pipe_q.b.col.u;
    assign c_gfx[2] = pipe_q.b.col.v;
    assign c_vid[0] = pipe_q.b.vid.y;
    assign c_vid[1] = pipe_q.b.vid.u;
    assign c_vid[2] = pipe_q.b.vid.v;

    for (genvar g = 0; g < NCOMP; g++) begin : g_comp
        gfxmix_mix #(.W(COMP_W), .TW(TRANS_W)) u_mix (
            .gfx   (c_gfx[g]),
            .vid   (c_vid[g]),
            .alpha (pipe_q.b.col.t),
            .mixed (c_mix[g])
        );
    end

    always_comb begin
        pipe_d = pipe_q;
        // stage a: index formation
        pipe_d.a.vld   = pix_valid;
        pipe_d.a.box   = box_active;
        pipe_d.a.idx   = lut_idx;
        pipe_d.a.vid.y = vid_y;
        pipe_d.a.vid.u = vid_u;
        pipe_d.a.vid.v = vid_v;
        // stage b: palette read
        pipe_d.b.vld   = pipe_q.a.vld;
        pipe_d.b.box   = pipe_q.a.box;
        pipe_d.b.col   = lut_col;
        pipe_d.b.vid   = pipe_q.a.vid;
        // stage c: blend or pass
        pipe_d.c.vld   = pipe_q.b.vld;
        if (pipe_q.b.box) begin
            pipe_d.c.pix.y = c_mix[0];
            pipe_d.c.pix.u = c_mix[1];
            pipe_d.c.pix.v = c_mix[2];
        end else begin
            pipe_d.c.pix = pipe_q.b.vid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.c.vld;
    assign out_y     = pipe_q.c.pix.y;
    assign out_u     = pipe_q.c.pix.u;
    assign out_v     = pipe_q.c.pix.v;

    // R9: full weight shows the palette colour
    p_opaque_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.b.box && pipe_q.b.col.t == '1) |=>
        (out_y == $past(pipe_q.b.col.y) && out_u == $past(pipe_q.b.col.u)
         && out_v == $past(pipe_q.b.col.v)));

    // R9: zero weight shows the video
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.b.box && pipe_q.b.col.t == '0) |=>
        (out_y == $past(pipe_q.b.vid.y) && out_u == $past(pipe_q.b.vid.u)
         && out_v == $past(pipe_q.b.vid.v)));

    // R10: outside a box the video is untouched
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.b.box |=> (out_y == $past(pipe_q.b.vid.y)
         && out_u == $past(pipe_q.b.vid.u) && out_v == $past(pipe_q.b.vid.v)));

    // R8: a blend never leaves the span between its two inputs
    p_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.b.box |=>
        ((out_y >= $past(pipe_q.b.col.y) || out_y >= $past(pipe_q.b.vid.y))
         && (out_y <= $past(pipe_q.b.col.y) || out_y <= $past(pipe_q.b.vid.y))));

    // R2: valid follows the stage before it by exactly one edge
    p_valid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.b.vld |=> out_valid);
endmodule

// File: tb/sim_gfxmix_top.sv
module sim_gfxmix_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0, hw_sel = 1'b0;
    logic [7:0]  hw_addr = '0;
    logic [29:0] hw_data = '0;
    logic        box_active = 1'b0, pix_valid = 1'b0;
    logic [1:0]  pix_bpp = '0, map_mode = '0;
    logic [7:0]  pix_code = '0, vid_y = '0, vid_u = '0, vid_v = '0;
    logic        out_valid;
    logic [7:0]  out_y, out_u, out_v;

    gfxmix_top u0 (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    string tag = "R1";
    bit done = 0;

    // behavioural model state
    int cy[256], cu[256], cv[256], ct[256], rm[16];
    int p_vld, p_box, p_idx, p_y, p_u, p_v;
    int m_vld, m_y, m_u, m_v;
    int e_vld, e_y, e_u, e_v;

    function automatic int blend(int g, int v, int t);
        return (t * g + (63 - t) * v + 31) / 63;
    endfunction

    function automatic int index_of(int code, int bpp, int mode);
        int m;
        m = (bpp == 0) ? (code & 3) : (bpp == 1) ? (code & 15) : (code & 255);
        case (mode)
            1: return rm[m & 15];
            2: return rm[m & 3];
            3: return rm[m & 3] & 15;
            default: return m;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            p_vld = 0; p_box = 0; p_idx = 0; p_y = 0; p_u = 0; p_v = 0;
            m_vld = 0; m_y = 0; m_u = 0; m_v = 0;
            e_vld = 0; e_y = 0; e_u = 0; e_v = 0;
        end else begin
            e_vld = m_vld; e_y = m_y; e_u = m_u; e_v = m_v;
            m_vld = p_vld;
            if (p_box != 0) begin
                m_y = blend(cy[p_idx], p_y, ct[p_idx]);
                m_u = blend(cu[p_idx], p_u, ct[p_idx]);
                m_v = blend(cv[p_idx], p_v, ct[p_idx]);
            end else begin
                m_y = p_y; m_u = p_u; m_v = p_v;
            end
            p_vld = int'(pix_valid); p_box = int'(box_active);
            p_idx = index_of(int'(pix_code), int'(pix_bpp), int'(map_mode));
            p_y = int'(vid_y); p_u = int'(vid_u); p_v = int'(vid_v);
            if (hw_en && !box_active) begin
                if (hw_sel) rm[int'(hw_addr) & 15] = int'(hw_data[7:0]);
                else begin
                    cy[hw_addr] = int'(hw_data[29:22]);
                    cu[hw_addr] = int'(hw_data[21:14]);
                    cv[hw_addr] = int'(hw_data[13:6]);
                    ct[hw_addr] = int'(hw_data[5:0]);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(out_valid) != e_vld) begin
                fails++;
                $display("FAIL %s: out_valid=%0d expected %0d", tag, out_valid, e_vld);
            end
            if (e_vld != 0) begin
                checks++;
                if (int'(out_y) != e_y || int'(out_u) != e_u || int'(out_v) != e_v) begin
                    fails++;
                    $display("FAIL %s: out=%0d/%0d/%0d expected %0d/%0d/%0d",
                             tag, out_y, out_u, out_v, e_y, e_u, e_v);
                end
            end
        end
    end

    task automatic cyc(input bit we, input bit sel, input int addr, input int data,
                       input bit box, input bit vld, input int bpp, input int mode,
                       input int code);
        @(negedge clk);
        hw_en = we; hw_sel = sel; hw_addr = 8'(addr); hw_data = 30'(data);
        box_active = box; pix_valid = vld; pix_bpp = 2'(bpp); map_mode = 2'(mode);
        pix_code = 8'(code);
        vid_y = 8'($urandom % 256); vid_u = 8'($urandom % 256); vid_v = 8'($urandom % 256);
    endtask

    task automatic wr_pal(input int a, input int y, input int u, input int v, input int t);
        cyc(1, 0, a, (y << 22) | (u << 14) | (v << 6) | t, 0, 0, 0, 0, 0);
    endtask

    task automatic px(input int bpp, input int mode, input int code);
        cyc(0, 0, 0, 0, 1, 1, bpp, mode, code);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_y !== 8'd0 || out_u !== 8'd0 || out_v !== 8'd0) begin
            fails++;
            $display("FAIL R1: out=%0d %0d/%0d/%0d expected 0 0/0/0", out_valid, out_y, out_u, out_v);
        end
        rst_n = 1'b1;

        tag = "R11";
        for (int i = 0; i < 256; i++)
            wr_pal(i, i, 255 - i, (i * 7) & 255, (i * 5) % 64);
        for (int k = 0; k < 16; k++)
            cyc(1, 1, k, (k * 37 + 11) & 255, 0, 0, 0, 0, 0);

        tag = "R4";
        for (int i = 0; i < 256; i++) px(2, 0, i);

        tag = "R2";
        for (int i = 0; i < 60; i++)
            cyc(0, 0, 0, 0, 1, bit'($urandom % 2), 2, 0, int'($urandom % 256));

        tag = "R3";
        for (int i = 0; i < 64; i++) px(i % 2, 0, int'($urandom % 256));
        for (int i = 0; i < 16; i++) px(3, 0, 240 + i);

        tag = "R5";
        for (int i = 0; i < 48; i++) px(1 + (i % 3), 1, int'($urandom % 256));
        tag = "R6";
        for (int i = 0; i < 32; i++) px(i % 4, 2, int'($urandom % 256));
        tag = "R7";
        for (int i = 0; i < 32; i++) px(i % 4, 3, int'($urandom % 256));

        tag = "R9";
        wr_pal(0, 200, 20, 90, 63);
        wr_pal(1, 10, 250, 30, 0);
        for (int i = 0; i < 16; i++) px(2, 0, i % 2);

        tag = "R8";
        for (int i = 0; i < 24; i++)
            wr_pal(i + 100, int'($urandom % 256), int'($urandom % 256),
                   int'($urandom % 256), int'($urandom % 64));
        for (int i = 0; i < 64; i++) px(2, 0, 100 + (i % 24));

        tag = "R10";
        for (int i = 0; i < 40; i++)
            cyc(0, 0, 0, 0, 0, 1, int'($urandom % 4), int'($urandom % 4), int'($urandom % 256));

        tag = "R11";
        cyc(1, 0, 5, 30'h3FFFFFFF, 1, 1, 2, 0, 5);
        cyc(1, 1, 2, 8'h00, 1, 1, 2, 0, 7);
        for (int i = 0; i < 4; i++) px(2, 0, 5);
        for (int i = 0; i < 4; i++) px(2, 2, 2);

        tag = "R12";
        px(2, 0, 9);
        wr_pal(9, 1, 2, 3, 63);
        px(2, 0, 9);
        px(2, 0, 9);

        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (6) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule